// File: doc/BRIEF.md
# Host Response Timeout Timer

This block watches a parallel-port peripheral controller for a remote host that stops answering. When the protocol state machine moves into a step where it must wait for a host-generated event, it pulses `wait_start`. The timer then restarts from zero and counts. The count ends in one of two ways. If `host_evt` arrives first, counting stops quietly. If the programmed limit is reached first, a sticky interrupt request is raised toward the local CPU.

The timebase divides the system clock by 2^PRE_W, which is 2048 by default. Each divided tick advances a CNT_W-bit up-counter, 14 bits by default. Only the upper LIMIT_W bits of that counter (8 by default) are compared against the programmed limit, so one step of the limit spans 2^(PRE_W+CNT_W-LIMIT_W) clock cycles. At 25 MHz, a limit of 0xC0 gives roughly one second.

Software reaches the block through a small register bus with two locations. One holds the limit. The other holds status: the pending interrupt and a running flag.

Top module: `htt_timer`

## Requirements
- R1: After reset, the limit register (address 0) reads 0xFF, the status register (address 1) reads 0x00, and `irq` is low.
- R2: A write to address 0 stores `reg_wdata` as the limit, and a read of address 0 returns it. Reads are combinational on `reg_addr`.
- R3: With limit L, `irq` rises on exactly rising edge N+1 after the edge that samples `wait_start`, where N = L·2^(PRE_W+CNT_W-LIMIT_W).
- R4: A `host_evt` sampled while running stops the count. Running clears on the next edge, and no interrupt follows however long the block then stays idle.
- R5: If `host_evt` is sampled on the same edge at which the limit match would raise the timeout, the host event wins: no interrupt is raised, and running clears.
- R6: A `wait_start` restarts both the prescaler and the counter from zero, even while a wait is already in progress. The timeout interval is then measured afresh from that pulse.
- R7: The interrupt is sticky and appears in status bit 0. Writing 1 to status bit 0 clears it. Writing 0 to that bit leaves it unchanged, and so does a new `wait_start`.
- R8: Status bit 1 (running) reads 1 from the edge that samples `wait_start` until the edge that ends the wait by host event or by timeout.
- R9: A limit of 0 raises the timeout on the first edge after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wait_start | input | 1 | Pulse: the port has entered a step that awaits a host event |
| host_evt | input | 1 | The awaited host event has occurred |
| reg_addr | input | 1 | Register select: 0 for the limit, 1 for status |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Sticky timeout interrupt request |

## Verification
The bench builds the timer with PRE_W=2, CNT_W=10 and LIMIT_W=8. One limit step is then 16 cycles rather than 2^17, so the exact edge of a timeout can be counted directly, including the full-scale 0xFF default. Restarting a wait 22 cycles into a previous one leaves the prescaler at a non-zero phase. A timer that failed to clear the prescaler on restart would therefore fire two cycles early, and that error is visible at the ports. The same small constants let a host event be placed on the very edge where the match would fire.

// File: rtl/htt_pkg.sv
package htt_pkg;
  localparam int unsigned REG_AW      = 1;
  localparam int unsigned REG_DW      = 8;
  localparam logic [REG_AW-1:0] ADDR_LIMIT  = 1'b0;
  localparam logic [REG_AW-1:0] ADDR_STATUS = 1'b1;
  localparam int unsigned ST_IRQ_BIT  = 0;
  localparam int unsigned ST_RUN_BIT  = 1;
endpackage

// File: rtl/htt_prescale.sv
module htt_prescale #(
  parameter int unsigned PRE_W = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  logic [PRE_W-1:0] div_q, div_d;

  assign tick = en && !clr && (&div_q);

  always_comb begin
    div_d = div_q;
    if (clr)     div_d = '0;
    else if (en) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/htt_count.sv
module htt_count #(
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               tick,
  input  logic [LIMIT_W-1:0] limit,
  output logic               match
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign match = (cnt_q[CNT_W-1 -: LIMIT_W] == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/htt_ctrl.sv
module htt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic host_evt,
  input  logic match,
  output logic run,
  output logic tmo
);
  logic run_d;

  assign tmo = run && match && !host_evt && !start;

  always_comb begin
    run_d = run;
    if (start)                          run_d = 1'b1;
    else if (run && (host_evt || match)) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= run_d;
  end

  // R8
  run_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run);

  // R4
  host_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && host_evt && !start) |=> !run);
endmodule

// File: rtl/htt_regs.sv
module htt_regs
  import htt_pkg::*;
#(
  parameter int unsigned LIMIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              tmo,
  input  logic              run,
  output logic [LIMIT_W-1:0] limit,
  output logic [REG_DW-1:0] rdata,
  output logic              irq
);
  logic [LIMIT_W-1:0] limit_d;
  logic               irq_d;
  logic               wr_lim, wr_clr;

  assign wr_lim = wr && (addr == ADDR_LIMIT);
  assign wr_clr = wr && (addr == ADDR_STATUS) && wdata[ST_IRQ_BIT];

  always_comb begin
    limit_d = limit;
    if (wr_lim) limit_d = wdata[LIMIT_W-1:0];
    irq_d = irq;
    if (tmo)         irq_d = 1'b1;
    else if (wr_clr) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit <= '1;
      irq   <= 1'b0;
    end else begin
      limit <= limit_d;
      irq   <= irq_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_LIMIT) begin
      rdata[LIMIT_W-1:0] = limit;
    end else begin
      rdata[ST_IRQ_BIT] = irq;
      rdata[ST_RUN_BIT] = run;
    end
  end

  // R2
  limit_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lim |=> (limit == $past(wdata[LIMIT_W-1:0])));

  // R3
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tmo));

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_clr) |=> irq);
endmodule

// File: rtl/htt_timer.sv
module htt_timer
  import htt_pkg::*;
#(
  parameter int unsigned PRE_W   = 11,
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned LIMIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_start,
  input  logic              host_evt,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq
);
  logic [1:0]         rs_q;
  logic               rst_i;
  logic               tick, match, run, tmo;
  logic [LIMIT_W-1:0] limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  htt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_i), .clr(wait_start), .en(run), .tick(tick)
  );

  htt_count #(.CNT_W(CNT_W), .LIMIT_W(LIMIT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i), .clr(wait_start), .tick(tick),
    .limit(limit), .match(match)
  );

  htt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i), .start(wait_start), .host_evt(host_evt),
    .match(match), .run(run), .tmo(tmo)
  );

  htt_regs #(.LIMIT_W(LIMIT_W)) u_regs (
    .clk(clk), .rst_n(rst_i), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .tmo(tmo), .run(run), .limit(limit),
    .rdata(reg_rdata), .irq(irq)
  );
endmodule

// File: tb/sim_htt_timer.sv
module sim_htt_timer;
  localparam int PRE_W = 2, CNT_W = 10, LIMIT_W = 8;
  localparam int STEP  = 1 << (PRE_W + CNT_W - LIMIT_W);

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wait_start = 1'b0, host_evt = 1'b0;
  logic [0:0] reg_addr = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  htt_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W), .LIMIT_W(LIMIT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wait_start(wait_start), .host_evt(host_evt),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_start;
    @(negedge clk);
    wait_start = 1'b1;
    @(negedge clk);
    wait_start = 1'b0;
    #1;
  endtask

  task automatic measure(input int maxn, output int hit);
    hit = 0;
    for (int n = 1; n <= maxn; n++) begin
      @(negedge clk);
      #1;
      if (irq && hit == 0) hit = n;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    reg_read(1'b0, d);
    chk(d == 8'hFF, "R1 limit", d, 8'hFF);
    reg_read(1'b1, d);
    chk(d == 8'h00, "R1 status", d, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
  endtask

  task automatic t_default;
    int hit;
    pulse_start();
    measure(255 * STEP + 10, hit);
    chk(hit == 255 * STEP + 1, "R3 default limit", hit, 255 * STEP + 1);
    reg_write(1'b1, 8'h01);
  endtask

  task automatic t_regrw;
    logic [7:0] d;
    reg_write(1'b0, 8'h5A);
    reg_read(1'b0, d);
    chk(d == 8'h5A, "R2 readback", d, 8'h5A);
    reg_write(1'b0, 8'h03);
    reg_read(1'b0, d);
    chk(d == 8'h03, "R2 readback", d, 3);
  endtask

  task automatic t_timeout;
    int hit;
    logic [7:0] d;
    pulse_start();
    reg_read(1'b1, d);
    chk(d[1] == 1'b1, "R8 running after start", d[1], 1);
    measure(3 * STEP + 10, hit);
    chk(hit == 3 * STEP + 1, "R3 timeout edge", hit, 3 * STEP + 1);
    reg_read(1'b1, d);
    chk(d == 8'h01, "R8 status after timeout", d, 1);
  endtask

  task automatic t_sticky;
    logic [7:0] d;
    reg_write(1'b1, 8'h00);
    chk(irq == 1'b1, "R7 write 0 keeps irq", irq, 1);
    pulse_start();
    reg_read(1'b1, d);
    chk(d == 8'h03, "R7 start keeps irq", d, 3);
    @(negedge clk); host_evt = 1'b1;
    @(negedge clk); host_evt = 1'b0;
    reg_write(1'b1, 8'h01);
    reg_read(1'b1, d);
    chk(d == 8'h00, "R7 clear by writing 1", d, 0);
    chk(irq == 1'b0, "R7 irq low after clear", irq, 0);
  endtask

  task automatic t_host_early;
    int hit;
    logic [7:0] d;
    pulse_start();
    for (int i = 0; i < 10; i++) @(negedge clk);
    host_evt = 1'b1;
    @(negedge clk); host_evt = 1'b0;
    #1;
    reg_read(1'b1, d);
    chk(d[1] == 1'b0, "R4 running cleared", d[1], 0);
    measure(6 * STEP, hit);
    chk(hit == 0, "R4 no irq after host event", hit, 0);
  endtask

  task automatic t_same_cycle;
    int hit;
    logic [7:0] d;
    pulse_start();
    for (int i = 0; i < 3 * STEP; i++) @(negedge clk);
    host_evt = 1'b1;
    @(negedge clk); host_evt = 1'b0;
    #1;
    chk(irq == 1'b0, "R5 host wins tie", irq, 0);
    reg_read(1'b1, d);
    chk(d == 8'h00, "R5 status after tie", d, 0);
    measure(2 * STEP, hit);
    chk(hit == 0, "R5 no late irq", hit, 0);
  endtask

  task automatic t_restart;
    int hit;
    pulse_start();
    for (int i = 0; i < 20; i++) @(negedge clk);
    pulse_start();
    measure(3 * STEP + 10, hit);
    chk(hit == 3 * STEP + 1, "R6 restart interval", hit, 3 * STEP + 1);
    reg_write(1'b1, 8'h01);
  endtask

  task automatic t_zero;
    int hit;
    reg_write(1'b0, 8'h00);
    pulse_start();
    measure(5, hit);
    chk(hit == 1, "R9 zero limit", hit, 1);
    reg_write(1'b1, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_default();
    t_regrw();
    t_timeout();
    t_sticky();
    t_host_early();
    t_same_cycle();
    t_restart();
    t_zero();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule